// File: doc/BRIEF.md
# Interrupt Redirection Table Controller

This block turns a set of interrupt input pins into interrupt messages. Each pin has its own 64-bit table entry. The entry sets the message vector, the delivery mode, the destination IDs, the active level of the pin, edge or level triggering, a mask bit and a flush-bypass bit. Software reaches the table one 32-bit word at a time through a simple register port. Two other registers sit on the same port: a read-only arbitration ID register and a read-only version register.

Edge-triggered pins latch a pending flag on each active edge. A level-triggered pin sends one message and then sets a remote-pending bit. That bit blocks further messages from the pin until an end-of-interrupt carrying the same vector clears it. Pending pins are served in round-robin order, and only one message is in flight at a time. When an entry's flush-bypass bit is clear, the block first raises a flush request and waits for the flush acknowledge before it offers the message. Messages leave on a valid/ready output. The `ext_mode` input picks the extended destination format, in which the extended destination ID byte is used. In the legacy format that byte is not used.

Top module: `irq_redir_ctrl`

## Requirements
- R1: After reset, every entry has its mask bit set and all other fields cleared. A read of any entry's low word returns 0x0001_0000 and a read of its high word returns 0. Neither msg_valid nor flush_req is asserted.
- R2: The table starts at dword offset 0x10. Entry i has its low word at offset 0x10+2i and its high word at offset 0x11+2i. reg_rdata updates on the clock edge that samples reg_rd. Offsets that map to nothing read 0 and ignore writes.
- R3: Low-word fields are: vector in bits 7:0, delivery mode in bits 10:8, active-low in bit 13, remote-pending (read-only) in bit 14, level trigger in bit 15, mask in bit 16 and flush bypass in bit 17. In the high word, the destination ID is in bits 31:24 and the extended ID in bits 23:16. All other bits ignore writes and read 0. With ext_mode=1 and all-ones written, the low word reads 0x0003_A7FF and the high word reads 0xFFFF_0000.
- R4: With ext_mode=0, writes to the extended ID byte are ignored and the byte reads 0. The msg_dest_eid output is also 0 in this mode. The stored byte reappears when ext_mode returns to 1.
- R5: Offset 0x02 reads {4'b0, arb_id, 24'b0}. Offset 0x01 reads the version word: entry count minus one in bits 23:16, and 0x20 in bits 7:0.
- R6: While an entry's mask bit is 1, the pin produces no message, and an edge that arrives while masked is not remembered.
- R7: With the active-low bit set, a falling pin is the active edge and a rising pin sends nothing.
- R8: For an unmasked edge-triggered pin with the flush bypassed, msg_valid rises on the second rising clock edge after the active pin edge. One message is sent per edge.
- R9: For a level-triggered pin, msg_valid rises on the first clock edge at which the active level is seen. The remote-pending bit then sets and blocks further messages. An end-of-interrupt whose vector differs leaves it set. A matching one clears it, after which a still-active pin sends again.
- R10: With flush bypass 0, flush_req rises at the point where msg_valid would have risen. msg_valid stays low until flush_done is sampled high. msg_valid then rises on that edge and flush_req falls. With bypass 1, flush_req never rises.
- R11: A message carries the entry's vector, delivery mode and destination IDs. These outputs and msg_valid hold steady while msg_ready is low.
- R12: Pending pins are granted in round-robin order, starting after the last granted pin. The next message is offered no earlier than one cycle after the previous handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Dword offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| arb_id | input | 4 | Arbitration ID shown at offset 0x02 |
| ext_mode | input | 1 | 1 = extended destination format |
| irq_pins | input | NUM_PINS | Interrupt input pins |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector of the end-of-interrupt |
| flush_req | output | 1 | Flush request ahead of a message |
| flush_done | input | 1 | Flush acknowledge |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message accepted |
| msg_vector | output | 8 | Message vector |
| msg_dmode | output | 3 | Message delivery mode |
| msg_dest_id | output | 8 | Destination ID |
| msg_dest_eid | output | 8 | Extended destination ID, 0 in legacy format |

## Verification
Stimulus is driven on falling clock edges, and the bench counts rising edges until msg_valid appears. That count is compared with the timing in the requirements. An edge-triggered pin must take exactly two edges, and a level pin or a granted flush acknowledge must take exactly one. Register reads are sampled on the falling edge after the rising edge that captured reg_rd. The negative checks, for masked pins, wrong-polarity edges and blocked level pins, watch msg_valid for several cycles beyond the latency at which a message would have appeared.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

    localparam int         TABLE_BASE   = 16;
    localparam logic [7:0] OFF_VERSION  = 8'h01;
    localparam logic [7:0] OFF_ARBID    = 8'h02;
    localparam logic [7:0] VERSION_CODE = 8'h20;

    typedef struct packed {
        logic [7:0] dest_id;
        logic [7:0] dest_eid;
        logic       flush_en;
        logic       mask;
        logic       level;
        logic       act_low;
        logic [2:0] dmode;
        logic [7:0] vector;
    } rte_t;

    typedef struct packed {
        logic [7:0] vector;
        logic [2:0] dmode;
        logic [7:0] dest_id;
        logic [7:0] dest_eid;
    } msg_t;

    typedef enum logic [1:0] {ST_IDLE, ST_FLUSH, ST_SEND} seq_state_e;

    function automatic rte_t rte_reset();
        rte_t e;
        e      = '0;
        e.mask = 1'b1;
        return e;
    endfunction

    function automatic logic [31:0] pack_low(rte_t e, logic remote);
        return {14'b0, e.flush_en, e.mask, e.level, remote, e.act_low,
                2'b0, e.dmode, e.vector};
    endfunction

    function automatic logic [31:0] pack_high(rte_t e, logic ext);
        return {e.dest_id, (ext ? e.dest_eid : 8'h00), 16'b0};
    endfunction

    function automatic rte_t merge_low(rte_t e, logic [31:0] d);
        rte_t r;
        r          = e;
        r.vector   = d[7:0];
        r.dmode    = d[10:8];
        r.act_low  = d[13];
        r.level    = d[15];
        r.mask     = d[16];
        r.flush_en = d[17];
        return r;
    endfunction

    function automatic rte_t merge_high(rte_t e, logic [31:0] d, logic ext);
        rte_t r;
        r         = e;
        r.dest_id = d[31:24];
        if (ext) r.dest_eid = d[23:16];
        return r;
    endfunction

endpackage

// File: rtl/irq_rt_regs.sv
module irq_rt_regs
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int IDXW     = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     reg_wr,
    input  logic                     reg_rd,
    input  logic [7:0]               reg_addr,
    input  logic [31:0]              reg_wdata,
    output logic [31:0]              reg_rdata,
    input  logic [3:0]               arb_id,
    input  logic                     ext_mode,
    input  logic [NUM_PINS-1:0]      remote,
    output rte_t [NUM_PINS-1:0]      table_q
);
    localparam int TABLE_END = TABLE_BASE + 2 * NUM_PINS;

    logic [7:0]      off;
    logic            in_tbl;
    logic [IDXW-1:0] ent;
    logic            hi_half;
    logic [31:0]     rd_word;
    logic [NUM_PINS-1:0] mask_all;

    assign off     = reg_addr - 8'(TABLE_BASE);
    assign in_tbl  = (int'(reg_addr) >= TABLE_BASE) && (int'(reg_addr) < TABLE_END);
    assign ent     = off[IDXW:1];
    assign hi_half = off[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_PINS; i++) table_q[i] <= rte_reset();
        end else if (reg_wr && in_tbl) begin
            if (hi_half) table_q[ent] <= merge_high(table_q[ent], reg_wdata, ext_mode);
            else         table_q[ent] <= merge_low(table_q[ent], reg_wdata);
        end
    end

    always_comb begin
        rd_word = '0;
        if (in_tbl) begin
            rd_word = hi_half ? pack_high(table_q[ent], ext_mode)
                              : pack_low(table_q[ent], remote[ent]);
        end else if (reg_addr == OFF_ARBID) begin
            rd_word = {4'b0, arb_id, 24'b0};
        end else if (reg_addr == OFF_VERSION) begin
            rd_word = {8'b0, 8'(NUM_PINS - 1), 8'b0, VERSION_CODE};
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_word;
    end

    always_comb begin
        for (int i = 0; i < NUM_PINS; i++) mask_all[i] = table_q[i].mask;
    end

    AST_RESET_MASK: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&mask_all)) else $error("mask not set after reset"); // R1

endmodule

// File: rtl/irq_pin_sense.sv
module irq_pin_sense
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int IDXW     = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pins,
    input  rte_t [NUM_PINS-1:0] table_q,
    input  logic                grant,
    input  logic [IDXW-1:0]     grant_idx,
    input  logic                eoi_valid,
    input  logic [7:0]          eoi_vector,
    output logic [NUM_PINS-1:0] req,
    output logic [NUM_PINS-1:0] remote
);
    logic [NUM_PINS-1:0] norm;
    logic [NUM_PINS-1:0] prev_norm;
    logic [NUM_PINS-1:0] edge_pend;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        logic hit;
        logic eoi_hit;
        logic act_edge;

        assign norm[g]  = pins[g] ^ table_q[g].act_low;
        assign hit      = grant && (grant_idx == IDXW'(g));
        assign eoi_hit  = eoi_valid && (eoi_vector == table_q[g].vector);
        assign act_edge = norm[g] && !prev_norm[g] && !table_q[g].mask;

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_norm[g] <= 1'b0;
                edge_pend[g] <= 1'b0;
                remote[g]    <= 1'b0;
            end else begin
                prev_norm[g] <= norm[g];
                if (table_q[g].level) edge_pend[g] <= 1'b0;
                else if (act_edge)    edge_pend[g] <= 1'b1;
                else if (hit)         edge_pend[g] <= 1'b0;
                if (!table_q[g].level) remote[g] <= 1'b0;
                else if (hit)          remote[g] <= 1'b1;
                else if (eoi_hit)      remote[g] <= 1'b0;
            end
        end

        assign req[g] = !table_q[g].mask &&
                        (table_q[g].level ? (norm[g] && !remote[g]) : edge_pend[g]);

        AST_LEVEL_REMOTE: assert property (@(posedge clk) disable iff (rst)
            (hit && table_q[g].level) |=> remote[g]) else $error("remote not set"); // R9
    end

endmodule

// File: rtl/irq_rr_arb.sv
module irq_rr_arb #(
    parameter int NUM_PINS = 8,
    parameter int IDXW     = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] req,
    input  logic [IDXW-1:0]     last,
    output logic                found,
    output logic [IDXW-1:0]     pick
);
    always_comb begin
        int j;
        found = 1'b0;
        pick  = '0;
        j     = 0;
        for (int k = 1; k <= NUM_PINS; k++) begin
            j = (int'(last) + k) % NUM_PINS;
            if (!found && req[j]) begin
                found = 1'b1;
                pick  = IDXW'(j);
            end
        end
    end

    AST_PICK_VALID: assert property (@(posedge clk) disable iff (rst)
        found |-> req[pick]) else $error("grant to idle pin"); // R12

endmodule

// File: rtl/irq_redir_ctrl.sv
module irq_redir_ctrl
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [7:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [3:0]          arb_id,
    input  logic                ext_mode,
    input  logic [NUM_PINS-1:0] irq_pins,
    input  logic                eoi_valid,
    input  logic [7:0]          eoi_vector,
    output logic                flush_req,
    input  logic                flush_done,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [7:0]          msg_vector,
    output logic [2:0]          msg_dmode,
    output logic [7:0]          msg_dest_id,
    output logic [7:0]          msg_dest_eid
);
    localparam int IDXW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    rte_t [NUM_PINS-1:0] table_q;
    logic [NUM_PINS-1:0] remote;
    logic [NUM_PINS-1:0] req;
    logic                found;
    logic [IDXW-1:0]     pick;
    logic [IDXW-1:0]     last_idx;
    logic                grant;
    seq_state_e          state;
    msg_t                snap;
    logic                snap_flush_en;

    irq_rt_regs #(.NUM_PINS(NUM_PINS), .IDXW(IDXW)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .arb_id(arb_id), .ext_mode(ext_mode), .remote(remote), .table_q(table_q)
    );

    irq_pin_sense #(.NUM_PINS(NUM_PINS), .IDXW(IDXW)) u_sense (
        .clk(clk), .rst(rst), .pins(irq_pins), .table_q(table_q),
        .grant(grant), .grant_idx(pick), .eoi_valid(eoi_valid),
        .eoi_vector(eoi_vector), .req(req), .remote(remote)
    );

    irq_rr_arb #(.NUM_PINS(NUM_PINS), .IDXW(IDXW)) u_arb (
        .clk(clk), .rst(rst), .req(req), .last(last_idx),
        .found(found), .pick(pick)
    );

    assign grant = (state == ST_IDLE) && found;

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            last_idx      <= '0;
            snap          <= '0;
            snap_flush_en <= 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: if (found) begin
                    snap.vector   <= table_q[pick].vector;
                    snap.dmode    <= table_q[pick].dmode;
                    snap.dest_id  <= table_q[pick].dest_id;
                    snap.dest_eid <= table_q[pick].dest_eid;
                    snap_flush_en <= table_q[pick].flush_en;
                    last_idx      <= pick;
                    state         <= table_q[pick].flush_en ? ST_SEND : ST_FLUSH;
                end
                ST_FLUSH: if (flush_done) state <= ST_SEND;
                ST_SEND:  if (msg_ready)  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign msg_valid    = (state == ST_SEND);
    assign flush_req    = (state == ST_FLUSH);
    assign msg_vector   = snap.vector;
    assign msg_dmode    = snap.dmode;
    assign msg_dest_id  = snap.dest_id;
    assign msg_dest_eid = ext_mode ? snap.dest_eid : 8'h00;

    AST_MSG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) &&
        $stable(msg_dmode) && $stable(msg_dest_id))) else $error("message changed"); // R11

    AST_FLUSH_GATE: assert property (@(posedge clk) disable iff (rst)
        ($rose(msg_valid) && !snap_flush_en) |-> $past(flush_req && flush_done))
        else $error("sent before flush"); // R10

endmodule

// File: tb/irq_redir_ctrl_test.sv
module irq_redir_ctrl_test;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  arb_id = 4'hA;
    logic        ext_mode = 1'b1;
    logic [N-1:0] irq_pins = '0;
    logic        eoi_valid = 1'b0;
    logic [7:0]  eoi_vector = '0;
    logic        flush_req, flush_done = 1'b0;
    logic        msg_valid, msg_ready = 1'b0;
    logic [7:0]  msg_vector, msg_dest_id, msg_dest_eid;
    logic [2:0]  msg_dmode;

    int tests = 0, fails = 0, cyc = 0;

    always #10 clk = ~clk;

    irq_redir_ctrl #(.NUM_PINS(N)) uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .arb_id(arb_id), .ext_mode(ext_mode), .irq_pins(irq_pins),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .flush_req(flush_req),
        .flush_done(flush_done), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_vector(msg_vector), .msg_dmode(msg_dmode),
        .msg_dest_id(msg_dest_id), .msg_dest_eid(msg_dest_eid)
    );

    typedef struct packed {
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic        ext;
        logic [31:0] expect_rd;
    } row_t;

    localparam row_t ROWS [7] = '{
        '{8'h10, 32'hFFFF_FFFF, 1'b1, 32'h0003_A7FF},
        '{8'h11, 32'hFFFF_FFFF, 1'b1, 32'hFFFF_0000},
        '{8'h13, 32'hFFFF_FFFF, 1'b0, 32'hFF00_0000},
        '{8'h12, 32'h0001_2345, 1'b1, 32'h0001_2345},
        '{8'h1E, 32'h0001_00AA, 1'b1, 32'h0001_00AA},
        '{8'h1F, 32'h1234_0000, 1'b1, 32'h1234_0000},
        '{8'h20, 32'hFFFF_FFFF, 1'b1, 32'h0000_0000}
    };

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
    endtask

    task automatic wait_msg(input int lim, output int n);
        n = 0;
        while (!msg_valid && n < lim) begin @(negedge clk); n++; end
    endtask

    task automatic ack();
        msg_ready = 1'b1; @(negedge clk); msg_ready = 1'b0;
    endtask

    task automatic quiet(input int cycles, input string tag);
        logic seen = 1'b0;
        for (int i = 0; i < cycles; i++) begin @(negedge clk); seen |= msg_valid; end
        check(!seen, tag, 32'(seen), 32'd0);
    endtask

    task automatic send_eoi(input logic [7:0] v);
        @(negedge clk); eoi_valid = 1'b1; eoi_vector = v;
        @(negedge clk); eoi_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            finish_run();
        end
    end

    initial begin
        logic [31:0] rv;
        int n;
        logic [7:0] got [4];

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h10, rv); check(rv == 32'h0001_0000, "R1 low word", rv, 32'h0001_0000);
        rd(8'h1E, rv); check(rv == 32'h0001_0000, "R1 last entry", rv, 32'h0001_0000);
        rd(8'h11, rv); check(rv == 32'h0, "R1 high word", rv, 32'h0);
        check(!msg_valid && !flush_req, "R1 outputs idle", {msg_valid, flush_req}, 0);

        // R5 identification registers
        rd(8'h02, rv); check(rv == 32'h0A00_0000, "R5 arb id", rv, 32'h0A00_0000);
        rd(8'h01, rv); check(rv == 32'h0007_0020, "R5 version", rv, 32'h0007_0020);
        rd(8'h03, rv); check(rv == 32'h0, "R2 unmapped read", rv, 32'h0);

        // R2 R3 R4 vector table walk
        for (int i = 0; i < 7; i++) begin
            ext_mode = ROWS[i].ext;
            wr(ROWS[i].addr, ROWS[i].wdata);
            rd(ROWS[i].addr, rv);
            check(rv == ROWS[i].expect_rd, "R2/R3 table row", rv, ROWS[i].expect_rd);
        end
        ext_mode = 1'b1;

        // R4 legacy format hides and protects the extended byte
        wr(8'h11, 32'h0123_0000);
        ext_mode = 1'b0;
        rd(8'h11, rv); check(rv == 32'h0100_0000, "R4 legacy read", rv, 32'h0100_0000);
        wr(8'h11, 32'h0245_0000);
        ext_mode = 1'b1;
        rd(8'h11, rv); check(rv == 32'h0223_0000, "R4 legacy write ignored", rv, 32'h0223_0000);

        // R6 masked edge pin
        wr(8'h10, 32'h0003_0031);
        @(negedge clk); irq_pins[0] = 1'b1;
        quiet(5, "R6 masked no message");
        wr(8'h10, 32'h0002_0031);
        quiet(4, "R6 masked edge not kept");
        @(negedge clk); irq_pins[0] = 1'b0;

        // R8 edge pin, R11 contents and hold, R10 bypass, R4 eid gating
        wr(8'h11, 32'h5A3C_0000);
        @(negedge clk); irq_pins[0] = 1'b1;
        wait_msg(8, n);
        check(n == 2, "R8 edge latency", n, 2);
        check(msg_vector == 8'h31 && msg_dest_id == 8'h5A && msg_dest_eid == 8'h3C,
              "R11 message fields", {msg_vector, msg_dest_id, msg_dest_eid}, 32'h315A3C);
        check(!flush_req, "R10 bypass no flush", flush_req, 0);
        repeat (3) @(negedge clk);
        check(msg_valid && msg_vector == 8'h31, "R11 held while not ready", msg_valid, 1);
        ext_mode = 1'b0; #1;
        check(msg_dest_eid == 8'h00, "R4 eid zero in legacy", msg_dest_eid, 0);
        ext_mode = 1'b1;
        ack();
        quiet(4, "R8 one message per edge");
        irq_pins[0] = 1'b0;

        // R7 active-low edge pin
        @(negedge clk); irq_pins[1] = 1'b1;
        wr(8'h12, 32'h0002_2542);
        quiet(3, "R7 no message on config");
        irq_pins[1] = 1'b0;
        wait_msg(8, n);
        check(n == 2 && msg_vector == 8'h42 && msg_dmode == 3'd5, "R7 falling edge fires",
              {n[7:0], msg_vector, 5'b0, msg_dmode}, {8'd2, 8'h42, 8'h05});
        ack();
        irq_pins[1] = 1'b1;
        quiet(4, "R7 rising edge ignored");

        // R9 level pin with remote pending
        wr(8'h14, 32'h0002_8055);
        @(negedge clk); irq_pins[2] = 1'b1;
        wait_msg(8, n);
        check(n == 1 && msg_vector == 8'h55, "R9 level latency", n, 1);
        ack();
        rd(8'h14, rv); check(rv == 32'h0002_C055, "R9 remote bit set", rv, 32'h0002_C055);
        quiet(4, "R9 blocked while remote");
        send_eoi(8'h56);
        quiet(3, "R9 wrong eoi keeps block");
        send_eoi(8'h55);
        wait_msg(4, n);
        check(msg_valid && n == 1, "R9 resend after eoi", n, 1);
        ack();
        irq_pins[2] = 1'b0;
        send_eoi(8'h55);
        rd(8'h14, rv); check(rv == 32'h0002_8055, "R9 remote cleared", rv, 32'h0002_8055);

        // R10 flush handshake
        wr(8'h16, 32'h0000_0066);
        @(negedge clk); irq_pins[3] = 1'b1;
        repeat (2) @(negedge clk);
        check(flush_req && !msg_valid, "R10 flush requested", {flush_req, msg_valid}, 2);
        repeat (3) @(negedge clk);
        check(flush_req && !msg_valid, "R10 waits for done", {flush_req, msg_valid}, 2);
        flush_done = 1'b1;
        wait_msg(4, n);
        check(n == 1 && !flush_req && msg_vector == 8'h66, "R10 send after done", n, 1);
        flush_done = 1'b0;
        ack();
        irq_pins[3] = 1'b0;

        // R12 round robin
        wr(8'h18, 32'h0002_0074);
        wr(8'h1A, 32'h0002_0075);
        wr(8'h1C, 32'h0002_0076);
        @(negedge clk); irq_pins[0] = 1'b1; irq_pins[6:4] = 3'b111;
        for (int k = 0; k < 4; k++) begin
            wait_msg(10, n); got[k] = msg_vector; ack();
        end
        check({got[0], got[1], got[2], got[3]} == 32'h7475_7631, "R12 rotation order",
              {got[0], got[1], got[2], got[3]}, 32'h7475_7631);
        irq_pins[0] = 1'b0; irq_pins[6:4] = 3'b000;
        @(negedge clk); irq_pins[0] = 1'b1; irq_pins[5] = 1'b1;
        wait_msg(10, n); got[0] = msg_vector; ack();
        check(!msg_valid, "R12 gap after handshake", msg_valid, 0);
        wait_msg(10, n); got[1] = msg_vector; ack();
        check({got[0], got[1]} == 16'h7531, "R12 starts after last grant",
              {16'h0, got[0], got[1]}, 32'h7531);

        finish_run();
    end
endmodule